// File: doc/BRIEF.md
# Paging Message Fragment Tracker

This block follows one long paging message whose pieces arrive in successive frames. Each piece comes in as a descriptor on a valid/ready stream. The descriptor holds four things: a message number, a fragment number, a continue bit and a flag that says whether the piece's checksum was good. A separate frame tick marks the end of each frame.

The first piece must carry fragment number 0. After that the expected number steps 1, 2, 0, 1, and so on. A set continue bit keeps the message open, and a clear continue bit closes it as complete. While a message is open, the tracker counts frames that pass without a new piece for that message. A mode pin selects the limit on that count: 32 frames or 128 frames. When the count reaches the limit, the message is dropped.

Every outcome appears as a single-cycle pulse one clock after the descriptor or tick that caused it. The outcomes are completion, a missing or out-of-order piece, a piece from another message, gap expiry and a bad checksum. A level output shows that a message is open.

Back-pressure rules: `frag_ready` goes high on the first clock after reset is released and stays high. A descriptor is taken on any rising edge where both `frag_valid` and `frag_ready` are high. The tracker never stalls the source. A source that holds `frag_valid` high hands over a new descriptor on every clock.

Top module: `frag_track`

## Requirements
- R1: While reset is held, and on the first clock after it, `msg_open` is low and every pulse output is low. `frag_ready` is low during reset and high from the first clock after reset is released.
- R2: A descriptor is accepted only on a clock where `frag_valid` and `frag_ready` are both high. Its outcome pulse appears on the clock edge that accepts it and lasts one cycle. `msg_done`, `frag_miss` and `gap_expired` never rise together.
- R3: With no message open, a descriptor with fragment number 0 and continue = 1 opens a message. The tracker records that descriptor's message number and then expects fragment number 1. A descriptor with fragment number 0 and continue = 0 pulses `msg_done` and leaves the tracker idle.
- R4: While a message is open, the expected fragment number follows 0→1→2→0 (2 wraps to 0). A descriptor from the same message with the expected number and continue = 1 advances the expected number. The same descriptor with continue = 0 pulses `msg_done` and closes the message.
- R5: Fragment numbers are 2 bits wide, and the value 3 is never expected. In the open state, a same-message descriptor whose number is not the expected one pulses `frag_miss` and closes the message. In the idle state, a descriptor with a nonzero number pulses `frag_miss` and the tracker stays idle.
- R6: While a message is open, a descriptor whose message number differs from the recorded one pulses `foreign_msg` and is otherwise ignored. The expected number, the recorded message number and the gap count all stay unchanged.
- R7: `frag_ok` = 0 on a descriptor that starts, advances or completes a message pulses `crc_err`. The sequence still moves as if the checksum were good. Descriptors that miss, or that belong to another message, never pulse `crc_err`.
- R8: While a message is open, each `frame_tick` without an accepted same-message descriptor on that clock adds one to the gap count. A descriptor that starts or advances the message clears the gap count. The limit is 32 when `long_gap` = 0 and 128 when `long_gap` = 1. The tick that brings the count to the limit pulses `gap_expired` and closes the message. A same-message descriptor on the same clock takes precedence over the tick.
- R9: `msg_open` is high exactly while a message is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frag_valid | input | 1 | Descriptor present on the stream |
| frag_ready | output | 1 | Tracker can take a descriptor |
| frag_msg | input | MSG_W | Message number of the descriptor |
| frag_num | input | 2 | Fragment number (0, 1, 2) |
| frag_cont | input | 1 | Continue bit: 1 means more pieces follow |
| frag_ok | input | 1 | Checksum of the piece was good |
| frame_tick | input | 1 | One-cycle pulse at each frame boundary |
| long_gap | input | 1 | Gap limit select: 0 = 32 frames, 1 = 128 frames |
| msg_open | output | 1 | A message is open |
| msg_done | output | 1 | Pulse: message completed |
| frag_miss | output | 1 | Pulse: missing or out-of-order piece |
| foreign_msg | output | 1 | Pulse: piece of another message ignored |
| gap_expired | output | 1 | Pulse: gap limit reached, message dropped |
| crc_err | output | 1 | Pulse: in-sequence piece with bad checksum |

## Verification
The assertions take for granted that `long_gap` stays constant while a message is open. They also assume that `frame_tick` and `frag_valid` carry their meaning on every cycle, with no idle marking beyond valid. Under those conditions the gap count never passes the longer limit, and every expiry follows a tick. The stimulus changes `long_gap` only when its own model shows the tracker idle. It mixes random ticks, descriptors from the open message and from other messages, right and wrong fragment numbers, and bad checksums. Directed runs then step the gap to one short of each limit and exactly to it.

// File: rtl/frag_pkg.sv
package frag_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_OPEN
  } trk_state_e;

  typedef enum logic [2:0] {
    J_NONE,
    J_START,
    J_ADV,
    J_LAST,
    J_MISS,
    J_FOREIGN
  } judge_e;

  typedef struct packed {
    logic done;
    logic miss;
    logic foreign;
    logic tmo;
    logic cerr;
  } trk_evt_t;

  function automatic logic [1:0] next_num(input logic [1:0] n);
    return (n == 2'd2) ? 2'd0 : n + 2'd1;
  endfunction

endpackage

// File: rtl/frag_judge.sv
module frag_judge
  import frag_pkg::*;
#(
  parameter int MSG_W = 8
) (
  input  logic             accept,
  input  logic             is_open,
  input  logic [MSG_W-1:0] cur_msg,
  input  logic [1:0]       exp_num,
  input  logic [MSG_W-1:0] in_msg,
  input  logic [1:0]       in_num,
  input  logic             in_cont,
  output judge_e           verdict
);

  always_comb begin
    verdict = J_NONE;
    if (accept) begin
      if (!is_open) begin
        if (in_num != 2'd0)    verdict = J_MISS;
        else if (in_cont)      verdict = J_START;
        else                   verdict = J_LAST;
      end else if (in_msg != cur_msg) begin
        verdict = J_FOREIGN;
      end else if (in_num != exp_num) begin
        verdict = J_MISS;
      end else if (in_cont) begin
        verdict = J_ADV;
      end else begin
        verdict = J_LAST;
      end
    end
  end

endmodule

// File: rtl/frag_gap.sv
module frag_gap #(
  parameter int SHORT_LIM = 32,
  parameter int LONG_LIM  = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  input  logic long_mode,
  output logic expire
);

  localparam int CW = $clog2(LONG_LIM + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim    = long_mode ? CW'(LONG_LIM) : CW'(SHORT_LIM);
  assign expire = run && !restart && tick && (cnt == lim - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt <= '0;
    else if (!run || restart || expire) cnt <= '0;
    else if (tick)                     cnt <= cnt + CW'(1);
  end

  assert_gap_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LONG_LIM));

  assert_gap_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

endmodule

// File: rtl/frag_seq.sv
module frag_seq
  import frag_pkg::*;
#(
  parameter int MSG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  judge_e           verdict,
  input  logic             expire,
  input  logic             accept,
  input  logic             in_ok,
  input  logic             in_cont,
  input  logic [MSG_W-1:0] in_msg,
  input  logic [1:0]       in_num,
  output logic             is_open,
  output logic [MSG_W-1:0] cur_msg,
  output logic [1:0]       exp_num,
  output logic             restart,
  output trk_evt_t         evt
);

  trk_state_e st;
  logic       in_seq;

  assign is_open = (st == ST_OPEN);
  assign in_seq  = (verdict == J_START) || (verdict == J_ADV) || (verdict == J_LAST);
  assign restart = in_seq || (verdict == J_MISS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cur_msg <= '0;
      exp_num <= 2'd0;
      evt     <= '0;
    end else begin
      evt      <= '0;
      evt.cerr <= in_seq && !in_ok;
      unique case (verdict)
        J_START, J_ADV: begin
          st      <= ST_OPEN;
          cur_msg <= in_msg;
          exp_num <= next_num(in_num);
        end
        J_LAST: begin
          st       <= ST_IDLE;
          exp_num  <= 2'd0;
          evt.done <= 1'b1;
        end
        J_MISS: begin
          st       <= ST_IDLE;
          exp_num  <= 2'd0;
          evt.miss <= 1'b1;
        end
        J_FOREIGN: begin
          evt.foreign <= 1'b1;
        end
        default: ;
      endcase
      if (expire && !restart) begin
        st      <= ST_IDLE;
        exp_num <= 2'd0;
        evt.tmo <= 1'b1;
      end
    end
  end

  assert_exp_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exp_num != 2'd3);

  assert_done_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt.done |-> $past(accept && !in_cont));

  assert_foreign_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt.foreign |-> (cur_msg == $past(cur_msg)) && (exp_num == $past(exp_num)));

  assert_cerr_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt.cerr |-> $past(accept && !in_ok));

endmodule

// File: rtl/frag_track.sv
module frag_track
  import frag_pkg::*;
#(
  parameter int MSG_W     = 8,
  parameter int SHORT_GAP = 32,
  parameter int LONG_GAP  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frag_valid,
  output logic             frag_ready,
  input  logic [MSG_W-1:0] frag_msg,
  input  logic [1:0]       frag_num,
  input  logic             frag_cont,
  input  logic             frag_ok,
  input  logic             frame_tick,
  input  logic             long_gap,
  output logic             msg_open,
  output logic             msg_done,
  output logic             frag_miss,
  output logic             foreign_msg,
  output logic             gap_expired,
  output logic             crc_err
);

  logic             accept;
  logic             is_open;
  logic [MSG_W-1:0] cur_msg;
  logic [1:0]       exp_num;
  logic             restart;
  logic             expire;
  judge_e           verdict;
  trk_evt_t         evt;

  always_ff @(posedge clk) begin
    if (!rst_n) frag_ready <= 1'b0;
    else        frag_ready <= 1'b1;
  end

  assign accept = frag_valid && frag_ready;

  frag_judge #(.MSG_W(MSG_W)) u_judge (
    .accept  (accept),
    .is_open (is_open),
    .cur_msg (cur_msg),
    .exp_num (exp_num),
    .in_msg  (frag_msg),
    .in_num  (frag_num),
    .in_cont (frag_cont),
    .verdict (verdict)
  );

  frag_gap #(.SHORT_LIM(SHORT_GAP), .LONG_LIM(LONG_GAP)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (is_open),
    .restart   (restart),
    .tick      (frame_tick),
    .long_mode (long_gap),
    .expire    (expire)
  );

  frag_seq #(.MSG_W(MSG_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .verdict (verdict),
    .expire  (expire),
    .accept  (accept),
    .in_ok   (frag_ok),
    .in_cont (frag_cont),
    .in_msg  (frag_msg),
    .in_num  (frag_num),
    .is_open (is_open),
    .cur_msg (cur_msg),
    .exp_num (exp_num),
    .restart (restart),
    .evt     (evt)
  );

  assign msg_open    = is_open;
  assign msg_done    = evt.done;
  assign frag_miss   = evt.miss;
  assign foreign_msg = evt.foreign;
  assign gap_expired = evt.tmo;
  assign crc_err     = evt.cerr;

  assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({msg_done, frag_miss, gap_expired}));

  assert_tmo_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gap_expired |-> $past(frame_tick) && !msg_open);

  assert_foreign_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    foreign_msg |-> $past(msg_open));

  assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frag_ready |=> frag_ready);

endmodule

// File: tb/sim_frag_track.sv
module sim_frag_track;

  localparam int MSG_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             frag_valid;
  logic             frag_ready;
  logic [MSG_W-1:0] frag_msg;
  logic [1:0]       frag_num;
  logic             frag_cont;
  logic             frag_ok;
  logic             frame_tick;
  logic             long_gap;
  logic             msg_open, msg_done, frag_miss, foreign_msg, gap_expired, crc_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  // bench reference state, built from the requirements
  bit             m_open = 1'b0;
  logic [MSG_W-1:0] m_msg = '0;
  logic [1:0]     m_exp = 2'd0;
  int             m_gap = 0;

  always #10 clk = ~clk;

  frag_track #(.MSG_W(MSG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .frag_valid(frag_valid), .frag_ready(frag_ready),
    .frag_msg(frag_msg), .frag_num(frag_num), .frag_cont(frag_cont), .frag_ok(frag_ok),
    .frame_tick(frame_tick), .long_gap(long_gap), .msg_open(msg_open),
    .msg_done(msg_done), .frag_miss(frag_miss), .foreign_msg(foreign_msg),
    .gap_expired(gap_expired), .crc_err(crc_err)
  );

  function automatic logic [1:0] nxt(input logic [1:0] n);
    return (n == 2'd2) ? 2'd0 : n + 2'd1;
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic cmp(input string tag, input logic act, input logic exp);
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle of stimulus; called at a falling edge
  task automatic step(input bit v, input logic [MSG_W-1:0] msg, input logic [1:0] num,
                      input bit cont, input bit ok, input bit tick);
    bit e_done = 0, e_miss = 0, e_for = 0, e_tmo = 0, e_cerr = 0;
    bit was_open = m_open;
    bit fed = 0;
    int lim = long_gap ? 128 : 32;
    frag_valid = v; frag_msg = msg; frag_num = num;
    frag_cont = cont; frag_ok = ok; frame_tick = tick;
    if (v) begin
      if (!m_open) begin
        if (num != 2'd0) e_miss = 1;                       // R5 idle
        else begin
          e_cerr = !ok;                                    // R7
          if (cont) begin m_open = 1; m_msg = msg; m_exp = 2'd1; m_gap = 0; end  // R3
          else e_done = 1;                                 // R3
        end
      end else if (msg != m_msg) begin
        e_for = 1;                                         // R6
      end else begin
        fed = 1;
        if (num != m_exp) begin e_miss = 1; m_open = 0; end  // R5
        else begin
          e_cerr = !ok;
          if (cont) begin m_exp = nxt(m_exp); m_gap = 0; end // R4
          else begin e_done = 1; m_open = 0; end
        end
      end
    end
    if (was_open && !fed && tick) begin                    // R8
      m_gap++;
      if (m_gap == lim) begin e_tmo = 1; m_open = 0; m_gap = 0; end
    end
    if (!m_open) m_gap = 0;
    @(posedge clk);
    #2;
    n_chk++;
    cmp("R4 msg_done", msg_done, e_done);
    cmp("R5 frag_miss", frag_miss, e_miss);
    cmp("R6 foreign_msg", foreign_msg, e_for);
    cmp("R8 gap_expired", gap_expired, e_tmo);
    cmp("R7 crc_err", crc_err, e_cerr);
    cmp("R9 msg_open", msg_open, m_open);
    cmp("R2 frag_ready", frag_ready, 1'b1);
    @(negedge clk);
    frag_valid = 0; frame_tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 2'd0, 0, 1, 1);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7319));
    rst_n = 0; frag_valid = 0; frag_msg = '0; frag_num = 0;
    frag_cont = 0; frag_ok = 1; frame_tick = 0; long_gap = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    cmp("R1 msg_open", msg_open, 1'b0);
    cmp("R1 pulses", msg_done | frag_miss | foreign_msg | gap_expired | crc_err, 1'b0);
    cmp("R1 frag_ready", frag_ready, 1'b0);
    rst_n = 1;
    @(posedge clk); #2;
    n_chk++;
    cmp("R1 ready after reset", frag_ready, 1'b1);
    cmp("R1 open after reset", msg_open, 1'b0);
    @(negedge clk);

    // R3: single piece message
    step(1, 8'h11, 2'd0, 0, 1, 0);
    // R3/R4: full chain with wrap 0,1,2,0,1 last
    step(1, 8'h22, 2'd0, 1, 1, 0);
    step(1, 8'h22, 2'd1, 1, 1, 1);
    step(1, 8'h22, 2'd2, 1, 0, 0);   // R7 bad checksum still advances
    step(1, 8'h22, 2'd0, 1, 1, 0);   // R4 wrap
    step(1, 8'h55, 2'd1, 1, 1, 1);   // R6 foreign
    step(1, 8'h22, 2'd1, 0, 1, 0);   // R4 done
    // R5: idle nonzero, open skip
    step(1, 8'h33, 2'd2, 1, 1, 0);
    step(1, 8'h33, 2'd0, 1, 1, 0);
    step(1, 8'h33, 2'd2, 1, 1, 0);
    // R8: short limit, one short then exact
    step(1, 8'h44, 2'd0, 1, 1, 0);
    ticks(31);
    step(1, 8'h44, 2'd1, 1, 1, 1);   // fragment beats tick
    ticks(32);
    // R8: long limit
    long_gap = 1;
    step(1, 8'h45, 2'd0, 1, 1, 0);
    ticks(127);
    step(1, 8'h45, 2'd1, 1, 1, 0);
    ticks(128);
    long_gap = 0;

    // random phase
    for (int i = 0; i < 6000; i++) begin
      bit v, tk, cont, ok;
      logic [MSG_W-1:0] msg;
      logic [1:0] num;
      int r = $urandom_range(0, 99);
      if (!m_open && $urandom_range(0, 19) == 0) long_gap = $urandom_range(0, 1);
      v  = (r < 45);
      tk = (r >= 30 && r < 80);
      if (m_open && $urandom_range(0, 3) != 0) msg = m_msg;
      else msg = MSG_W'($urandom_range(0, 7));
      if (m_open) num = ($urandom_range(0, 5) != 0) ? m_exp : 2'($urandom_range(0, 3));
      else        num = ($urandom_range(0, 4) != 0) ? 2'd0 : 2'($urandom_range(1, 3));
      cont = ($urandom_range(0, 9) < 7);
      ok   = ($urandom_range(0, 9) < 8);
      step(v, msg, num, cont, ok, tk);
    end
    finish_run();
  end

endmodule